// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Arbiter

This block keeps the pending state and the sampled line levels for a set of interrupt sources. From them it picks, separately for each of several processors, the most urgent interrupt that is both enabled and pending. Each processor gets its own request line and its own highest-pending interrupt ID. Sources fall into two groups:

- IDs below `N_BANKED` are banked per processor. Each one has its own priority for every processor, and it becomes pending only through a software set.
- IDs from `N_BANKED` upward are external. Each one is driven by a request line and has one priority shared by all processors, a target mask and an edge or level setting.

The surrounding logic supplies the configuration as plain inputs: source enables, edge flags, target masks and priorities. It also supplies the distributor and per-processor interface enables, each processor's priority mask and each processor's running priority. Register decoding, acknowledge and end-of-interrupt handling are outside this block. They reach the pending state only through the one-cycle set and clear inputs. Arbitration is combinational over registered state, so a state change captured at a clock edge shows on the outputs right after that edge.

Top module: `irq_prio_arb`

## Requirements
- R1: For each processor, the candidates are the IDs whose `src_en` bit is 1 and whose pending bit for that processor is 1. The winner is the candidate with the smallest priority value. On equal values, the lowest ID wins.
- R2: When a processor has no candidate, its best priority is the idle value 0x100, its `cpu_hpid` field reads 1023 and its `cpu_irq` bit is 0.
- R3: A processor's `cpu_hpid` field shows the winner only when the winner's priority is less than or equal to that processor's `prio_mask` field. Otherwise the field reads 1023.
- R4: A processor's `cpu_irq` bit is 1 only while the ID it shows has a priority strictly below that processor's 9-bit `run_prio` field. A value of 0x100 in that field means nothing is running.
- R5: While `dist_en` is 0, or the processor's `cpu_if_en` bit is 0, that processor's `cpu_irq` bit is 0 and its `cpu_hpid` field is 1023.
- R6: External line n drives ID `N_BANKED`+n. When the line rises above its stored level, the ID becomes pending for every processor c whose bit `src_tgt[n*N_CPU+c]` is 1. This happens only if `src_edge[n]` is 1 or the ID is enabled. A falling line only lowers the stored level.
- R7: A line that stays at its stored level has no effect, so a line held high does not make a cleared interrupt pending again.
- R8: IDs below `N_BANKED` take their priority from `prio_banked[(c*N_BANKED+i)*PRIO_W +: PRIO_W]` for processor c. External ID `N_BANKED`+n takes `prio_shared[n*PRIO_W +: PRIO_W]` for every processor.
- R9: `pend_set[c*N_ID+i]` makes ID i pending for processor c. `pend_clr[i]` clears ID i for all processors. When both act in the same cycle, the set wins. Otherwise a pending bit keeps its value.
- R10: After reset, no interrupt is pending and all stored line levels are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq | input | N_ID-N_BANKED | External request lines; line n is ID N_BANKED+n |
| dist_en | input | 1 | Global distributor enable |
| cpu_if_en | input | N_CPU | Per-processor interface enable |
| src_en | input | N_ID | Per-ID enable |
| src_edge | input | N_ID-N_BANKED | 1 = edge-triggered external ID |
| src_tgt | input | (N_ID-N_BANKED)*N_CPU | Target mask per external ID, bit n*N_CPU+c |
| prio_banked | input | N_CPU*N_BANKED*PRIO_W | Per-processor priorities of the banked IDs |
| prio_shared | input | (N_ID-N_BANKED)*PRIO_W | Shared priorities of the external IDs |
| pend_set | input | N_CPU*N_ID | One-cycle pending set, bit c*N_ID+i |
| pend_clr | input | N_ID | One-cycle pending clear for all processors |
| prio_mask | input | N_CPU*PRIO_W | Per-processor priority mask |
| run_prio | input | N_CPU*(PRIO_W+1) | Per-processor running priority, 0x100 = idle |
| cpu_irq | output | N_CPU | Per-processor interrupt request |
| cpu_hpid | output | N_CPU*10 | Per-processor highest-pending ID, 1023 = none |

## Verification
The bench probes several priority ties and expects the lower ID to win. A design that replaced the best candidate on equal priority would report the higher ID. It sets the mask equal to the winner's priority and the running priority equal to it as well. An off-by-one compare would then either hide an ID that should be shown or raise a request that should stay low. It holds an external line high across a pending clear, then lowers and raises it again. This catches a design that samples levels instead of rises, or one that pends a level-triggered source that was disabled at the rise. It also gives one banked ID a different priority on each processor, which exposes a design that shares that priority between processors.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // Width of an interrupt ID on the outputs
  localparam int ID_W = 10;
  // ID reported when nothing qualifies
  localparam logic [ID_W-1:0] NO_IRQ = 10'd1023;

  typedef logic [ID_W-1:0] irq_id_t;
endpackage

// File: rtl/irq_pend_store.sv
module irq_pend_store
  import irq_arb_pkg::*;
#(
  parameter int N_CPU    = 2,
  parameter int N_ID     = 64,
  parameter int N_BANKED = 32,
  localparam int N_EXT   = N_ID - N_BANKED,
  localparam int N_PEND  = N_CPU * N_ID
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXT-1:0]  ext_irq,
  input  logic [N_EXT-1:0]  ext_en,
  input  logic [N_EXT-1:0]  ext_edge,
  input  logic [N_EXT*N_CPU-1:0] ext_tgt,
  input  logic [N_PEND-1:0] pend_set,
  input  logic [N_ID-1:0]   pend_clr,
  output logic [N_PEND-1:0] pend_q
);

  logic [N_EXT-1:0]  lvl_q;
  logic [N_EXT-1:0]  lvl_d;
  logic              lvl_upd;
  logic [N_EXT-1:0]  rise;
  logic [N_PEND-1:0] pend_d;
  logic              pend_upd;

  // Stored level follows the line; only a real change is a rise or fall
  always_comb begin
    lvl_d   = ext_irq;
    rise    = ext_irq & ~lvl_q;
    lvl_upd = (ext_irq != lvl_q);
  end

  // Pending next state: clear first, then set, so a set wins
  always_comb begin
    for (int c = 0; c < N_CPU; c++) begin
      for (int i = 0; i < N_ID; i++) begin
        logic set_b;
        set_b = pend_set[c*N_ID+i];
        if (i >= N_BANKED) begin
          set_b = set_b | (rise[i-N_BANKED]
                           & (ext_edge[i-N_BANKED] | ext_en[i-N_BANKED])
                           & ext_tgt[(i-N_BANKED)*N_CPU+c]);
        end
        pend_d[c*N_ID+i] = (pend_q[c*N_ID+i] & ~pend_clr[i]) | set_b;
      end
    end
    pend_upd = (pend_d != pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else if (lvl_upd) begin
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_upd) begin
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_arb_pkg::*;
#(
  parameter int N_ID   = 64,
  parameter int PRIO_W = 8,
  localparam int BP_W  = PRIO_W + 1
) (
  input  logic [N_ID-1:0]        cand,
  input  logic [N_ID*PRIO_W-1:0] prio,
  output logic [BP_W-1:0]        best_prio,
  output irq_id_t                best_id
);

  localparam logic [BP_W-1:0] IDLE = BP_W'(1) << PRIO_W;

  // Ascending scan; strict compare keeps the lowest ID on a tie
  always_comb begin
    best_prio = IDLE;
    best_id   = NO_IRQ;
    for (int i = 0; i < N_ID; i++) begin
      if (cand[i] && ({1'b0, prio[i*PRIO_W +: PRIO_W]} < best_prio)) begin
        best_prio = {1'b0, prio[i*PRIO_W +: PRIO_W]};
        best_id   = ID_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_cpu_gate.sv
module irq_cpu_gate
  import irq_arb_pkg::*;
#(
  parameter int PRIO_W = 8,
  localparam int BP_W  = PRIO_W + 1
) (
  input  logic              dist_en,
  input  logic              if_en,
  input  logic [BP_W-1:0]   best_prio,
  input  irq_id_t           best_id,
  input  logic [PRIO_W-1:0] mask,
  input  logic [BP_W-1:0]   run,
  output logic              req,
  output irq_id_t           hpid
);

  always_comb begin
    req  = 1'b0;
    hpid = NO_IRQ;
    if (dist_en && if_en && (best_prio <= {1'b0, mask})) begin
      hpid = best_id;
      req  = (best_prio < run);
    end
  end

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int N_CPU    = 2,
  parameter int N_ID     = 64,
  parameter int N_BANKED = 32,
  parameter int PRIO_W   = 8,
  localparam int N_EXT   = N_ID - N_BANKED,
  localparam int RUN_W   = PRIO_W + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_EXT-1:0]             ext_irq,
  input  logic                         dist_en,
  input  logic [N_CPU-1:0]             cpu_if_en,
  input  logic [N_ID-1:0]              src_en,
  input  logic [N_EXT-1:0]             src_edge,
  input  logic [N_EXT*N_CPU-1:0]       src_tgt,
  input  logic [N_CPU*N_BANKED*PRIO_W-1:0] prio_banked,
  input  logic [N_EXT*PRIO_W-1:0]      prio_shared,
  input  logic [N_CPU*N_ID-1:0]        pend_set,
  input  logic [N_ID-1:0]              pend_clr,
  input  logic [N_CPU*PRIO_W-1:0]      prio_mask,
  input  logic [N_CPU*RUN_W-1:0]       run_prio,
  output logic [N_CPU-1:0]             cpu_irq,
  output logic [N_CPU*ID_W-1:0]        cpu_hpid
);

  logic [N_CPU*N_ID-1:0] pend_q;

  irq_pend_store #(
    .N_CPU   (N_CPU),
    .N_ID    (N_ID),
    .N_BANKED(N_BANKED)
  ) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_irq (ext_irq),
    .ext_en  (src_en[N_ID-1:N_BANKED]),
    .ext_edge(src_edge),
    .ext_tgt (src_tgt),
    .pend_set(pend_set),
    .pend_clr(pend_clr),
    .pend_q  (pend_q)
  );

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    logic [N_ID*PRIO_W-1:0] prio_v;
    logic [N_ID-1:0]        cand;
    logic [RUN_W-1:0]       best_prio;
    irq_id_t                best_id;
    irq_id_t                hpid;

    // Banked IDs read this processor's bank; external IDs read the shared set
    for (genvar i = 0; i < N_ID; i++) begin : g_prio
      if (i < N_BANKED) begin : g_bank
        assign prio_v[i*PRIO_W +: PRIO_W] =
          prio_banked[(c*N_BANKED+i)*PRIO_W +: PRIO_W];
      end else begin : g_shr
        assign prio_v[i*PRIO_W +: PRIO_W] =
          prio_shared[(i-N_BANKED)*PRIO_W +: PRIO_W];
      end
    end

    assign cand = src_en & pend_q[c*N_ID +: N_ID];

    irq_prio_pick #(
      .N_ID  (N_ID),
      .PRIO_W(PRIO_W)
    ) u_pick (
      .cand     (cand),
      .prio     (prio_v),
      .best_prio(best_prio),
      .best_id  (best_id)
    );

    irq_cpu_gate #(
      .PRIO_W(PRIO_W)
    ) u_gate (
      .dist_en  (dist_en),
      .if_en    (cpu_if_en[c]),
      .best_prio(best_prio),
      .best_id  (best_id),
      .mask     (prio_mask[c*PRIO_W +: PRIO_W]),
      .run      (run_prio[c*RUN_W +: RUN_W]),
      .req      (cpu_irq[c]),
      .hpid     (hpid)
    );

    assign cpu_hpid[c*ID_W +: ID_W] = hpid;
  end

endmodule

// File: rtl/irq_prio_arb_chk.sv
module irq_prio_arb_chk
  import irq_arb_pkg::*;
#(
  parameter int N_CPU    = 2,
  parameter int N_ID     = 64,
  parameter int N_BANKED = 32,
  parameter int PRIO_W   = 8,
  localparam int N_EXT   = N_ID - N_BANKED,
  localparam int RUN_W   = PRIO_W + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_EXT-1:0]        ext_irq,
  input logic                    dist_en,
  input logic [N_CPU-1:0]        cpu_if_en,
  input logic [N_CPU*N_ID-1:0]   pend_set,
  input logic [N_ID-1:0]         pend_clr,
  input logic [N_CPU*RUN_W-1:0]  run_prio,
  input logic [N_CPU*N_ID-1:0]   pend_q,
  input logic [N_CPU-1:0]        cpu_irq,
  input logic [N_CPU*ID_W-1:0]   cpu_hpid
);

  for (genvar c = 0; c < N_CPU; c++) begin : g_c
    // R5
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dist_en || !cpu_if_en[c]) |->
        (!cpu_irq[c] && cpu_hpid[c*ID_W +: ID_W] == NO_IRQ));

    // R2
    req_has_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[c] |-> (cpu_hpid[c*ID_W +: ID_W] != NO_IRQ));

    // R4
    run_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_prio[c*RUN_W +: RUN_W] == '0) |-> !cpu_irq[c]);

    for (genvar i = 0; i < N_ID; i++) begin : g_i
      // R9
      pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[c*N_ID+i] && !pend_clr[i]) |=> pend_q[c*N_ID+i]);

      if (i < N_BANKED) begin : g_b
        // R9
        bank_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
          $rose(pend_q[c*N_ID+i]) |-> $past(pend_set[c*N_ID+i]));
      end else begin : g_e
        // R6
        ext_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
          $rose(pend_q[c*N_ID+i]) |->
            ($past(pend_set[c*N_ID+i]) || $past(ext_irq[i-N_BANKED])));
      end
    end
  end

endmodule

bind irq_prio_arb irq_prio_arb_chk #(
  .N_CPU   (N_CPU),
  .N_ID    (N_ID),
  .N_BANKED(N_BANKED),
  .PRIO_W  (PRIO_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ext_irq  (ext_irq),
  .dist_en  (dist_en),
  .cpu_if_en(cpu_if_en),
  .pend_set (pend_set),
  .pend_clr (pend_clr),
  .run_prio (run_prio),
  .pend_q   (pend_q),
  .cpu_irq  (cpu_irq),
  .cpu_hpid (cpu_hpid)
);

// File: tb/sim_irq_prio_arb.sv
`timescale 1ns/1ps
module sim_irq_prio_arb;
  localparam int NC = 2;
  localparam int NI = 64;
  localparam int NB = 32;
  localparam int PW = 8;
  localparam int NE = NI - NB;
  localparam int RW = PW + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [NE-1:0]       ext_irq;
  logic                dist_en;
  logic [NC-1:0]       cpu_if_en;
  logic [NI-1:0]       src_en;
  logic [NE-1:0]       src_edge;
  logic [NE*NC-1:0]    src_tgt;
  logic [NC*NB*PW-1:0] prio_banked;
  logic [NE*PW-1:0]    prio_shared;
  logic [NC*NI-1:0]    pend_set;
  logic [NI-1:0]       pend_clr;
  logic [NC*PW-1:0]    prio_mask;
  logic [NC*RW-1:0]    run_prio;
  logic [NC-1:0]       cpu_irq;
  logic [NC*10-1:0]    cpu_hpid;

  always #2 clk = ~clk;

  irq_prio_arb u0 (
    .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .dist_en(dist_en),
    .cpu_if_en(cpu_if_en), .src_en(src_en), .src_edge(src_edge),
    .src_tgt(src_tgt), .prio_banked(prio_banked), .prio_shared(prio_shared),
    .pend_set(pend_set), .pend_clr(pend_clr), .prio_mask(prio_mask),
    .run_prio(run_prio), .cpu_irq(cpu_irq), .cpu_hpid(cpu_hpid)
  );

  typedef struct {
    logic [1:0] irq;
    int         id0;
    int         id1;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // Monitor: compares one queued item just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        n_vec++;
        if (cpu_irq !== e.irq || int'(cpu_hpid[9:0]) != e.id0 ||
            int'(cpu_hpid[19:10]) != e.id1) begin
          n_bad++;
          $display("FAIL %s: actual irq=%b id0=%0d id1=%0d expected irq=%b id0=%0d id1=%0d",
                   e.tag, cpu_irq, cpu_hpid[9:0], cpu_hpid[19:10], e.irq, e.id0, e.id1);
        end
      end
    end
  end

  // Driver: queue the expectation, let one edge pass, drop the pulses
  task automatic step(string tag, logic [1:0] irq, int id0, int id1);
    exp_t e;
    e.irq = irq; e.id0 = id0; e.id1 = id1; e.tag = tag;
    sbq.push_back(e);
    @(posedge clk);
    @(negedge clk);
    pend_set = '0;
    pend_clr = '0;
  endtask

  task automatic bank(int c, int i, logic [7:0] v);
    prio_banked[(c*NB+i)*PW +: PW] = v;
  endtask

  task automatic shared(int n, logic [7:0] v);
    prio_shared[n*PW +: PW] = v;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual running expected finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    ext_irq = '0; dist_en = 1'b0; cpu_if_en = '0; src_en = '0;
    src_edge = '0; src_tgt = '0; pend_set = '0; pend_clr = '0;
    for (int i = 0; i < NC*NB; i++) prio_banked[i*PW +: PW] = 8'h80;
    for (int i = 0; i < NE; i++) prio_shared[i*PW +: PW] = 8'h80;
    prio_mask = {8'hF0, 8'hF0};
    run_prio  = {9'h100, 9'h100};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    step("R5 R10 reset, distributor off", 2'b00, 1023, 1023);
    dist_en = 1'b1; cpu_if_en = 2'b11; src_en = '1;
    step("R2 R10 nothing pending", 2'b00, 1023, 1023);
    src_en = '0;

    // R1 basic win, tie, disabled candidate
    src_en[5] = 1'b1; bank(0, 5, 8'h40); pend_set[0*NI+5] = 1'b1;
    step("R1 single winner", 2'b01, 5, 1023);
    src_en[3] = 1'b1; bank(0, 3, 8'h40); pend_set[0*NI+3] = 1'b1;
    step("R1 tie lowest ID", 2'b01, 3, 1023);
    bank(0, 2, 8'h20); pend_set[0*NI+2] = 1'b1;
    step("R1 disabled ignored", 2'b01, 3, 1023);
    src_en[2] = 1'b1;
    step("R1 enabled wins", 2'b01, 2, 1023);

    // R3 mask boundary
    prio_mask[7:0] = 8'h1F;
    step("R3 mask below", 2'b00, 1023, 1023);
    prio_mask[7:0] = 8'h20;
    step("R3 mask equal", 2'b01, 2, 1023);

    // R4 running priority boundary
    run_prio[8:0] = 9'h020;
    step("R4 running equal", 2'b00, 2, 1023);
    run_prio[8:0] = 9'h021;
    step("R4 running above", 2'b01, 2, 1023);
    prio_mask[7:0] = 8'hF0; run_prio[8:0] = 9'h100;

    // R9 set beats clear, then clear
    pend_clr[2] = 1'b1; pend_clr[3] = 1'b1; pend_clr[5] = 1'b1;
    pend_set[0*NI+3] = 1'b1;
    step("R9 set wins over clear", 2'b01, 3, 1023);
    pend_clr[3] = 1'b1;
    step("R9 clear", 2'b00, 1023, 1023);

    // R8 banked priority per processor
    src_en[7] = 1'b1; bank(0, 7, 8'h50); bank(1, 7, 8'h10);
    pend_set[0*NI+7] = 1'b1; pend_set[1*NI+7] = 1'b1;
    step("R8 banked both", 2'b11, 7, 7);
    src_en[9] = 1'b1; bank(0, 9, 8'h30); bank(1, 9, 8'h60);
    pend_set[0*NI+9] = 1'b1; pend_set[1*NI+9] = 1'b1;
    step("R8 banked differ", 2'b11, 9, 7);
    pend_clr[7] = 1'b1; pend_clr[9] = 1'b1;
    step("R9 clear both", 2'b00, 1023, 1023);

    // R6 external, level-triggered, processor 1 target
    src_en[32] = 1'b1; src_tgt[0*NC+1] = 1'b1; shared(0, 8'h30);
    ext_irq[0] = 1'b1;
    step("R6 targeted rise", 2'b10, 1023, 32);
    pend_clr[32] = 1'b1;
    step("R7 steady high after clear", 2'b00, 1023, 1023);
    step("R7 still no repend", 2'b00, 1023, 1023);
    ext_irq[0] = 1'b0;
    step("R6 fall no pend", 2'b00, 1023, 1023);
    ext_irq[0] = 1'b1;
    step("R6 rise again", 2'b10, 1023, 32);

    // R6 level-triggered and disabled at the rise
    src_tgt[1*NC+0] = 1'b1; src_tgt[1*NC+1] = 1'b1; shared(1, 8'h10);
    ext_irq[1] = 1'b1;
    step("R6 disabled level", 2'b10, 1023, 32);
    src_en[33] = 1'b1;
    step("R6 no late pend", 2'b10, 1023, 32);

    // R6 edge-triggered and disabled at the rise: pend is kept
    src_edge[2] = 1'b1; src_tgt[2*NC+0] = 1'b1; shared(2, 8'h60);
    ext_irq[2] = 1'b1;
    step("R6 edge disabled", 2'b10, 1023, 32);
    src_en[34] = 1'b1;
    step("R6 edge latched", 2'b11, 34, 32);

    // R8 shared priority on both processors
    src_tgt[0*NC+0] = 1'b1; ext_irq[0] = 1'b0;
    step("R6 fall keeps pend", 2'b11, 34, 32);
    ext_irq[0] = 1'b1;
    step("R8 shared priority", 2'b11, 32, 32);

    // R5 enables
    cpu_if_en = 2'b01;
    step("R5 interface off", 2'b01, 32, 1023);
    dist_en = 1'b0;
    step("R5 distributor off", 2'b00, 1023, 1023);
    dist_en = 1'b1; cpu_if_en = 2'b11;
    step("R9 pend persists", 2'b11, 32, 32);

    @(posedge clk);
    #2;
    done = 1'b1;
    finish_run();
  end
endmodule